// File: doc/BRIEF.md
# Instruction Decoder and Control

This block turns one 16-bit instruction word of an eight-register processor into everything the datapath needs for that instruction. It pulls out the register indices, widens the 6-bit immediate, and produces the control set: register write enable and destination, ALU operation and second-operand source, data-memory read and write strobes, the write-back source, the terminal output strobe, and the kind of program-counter update.

The block is purely combinational and holds no state. The fetch stage places the instruction on `instr`, and the decoded fields are valid in the same cycle. It passes no data stream and has no flow control, so it has no valid/ready pins. Back-pressure belongs to the stages around it.

The opcode sits in bits [15:12]. Opcode 0000 takes its ALU operation from a 3-bit function field. The other opcodes select immediate arithmetic, loads and stores, keyboard input, terminal output, branches and jumps.

Top module: `instr_decode`

## Requirements
- R1: `src_a_idx` always equals instr[11:9], `src_b_idx` always equals instr[8:6], and `jaddr` always equals instr[11:0].
- R2: For opcode 0000 the outputs are:
  - `alu_op` equals the function field instr[2:0], using codes ADD=0, SUB=1, SLT=2, SRA=3, MUL=4, AND=5, OR=6, NOT=7.
  - `alu_src_imm` is 0.
  - `wb_sel` is ALU (code 0).
  - `wr_idx` equals instr[5:3].
  - The register write is requested.
- R3: For opcodes 0001, 0010, 0011 and 0100 the outputs are:
  - `alu_op` is 0, 1, 5 and 6 respectively.
  - `alu_src_imm` is 1.
  - `wb_sel` is ALU (0).
  - `wr_idx` equals instr[8:6].
  - The register write is requested.
- R4: `imm_val` is instr[5:0] zero-extended for opcodes 0011 and 0100. It is sign-extended for opcodes 0001, 0010, 0111 and 1000.
- R5: For opcode 0111 the outputs are:
  - `mem_rd` is 1 and `mem_wr` is 0.
  - `wb_sel` is memory (code 1).
  - `alu_op` is ADD (0) and `alu_src_imm` is 1.
  - `wr_idx` equals instr[8:6].
- R6: For opcode 1000 the outputs are:
  - `mem_wr` is 1 and `mem_rd` is 0.
  - `wr_en` is 0.
  - `alu_op` is ADD (0) and `alu_src_imm` is 1.
- R7: Opcode 1001 requests a write of `wr_idx` = instr[8:6] with `wb_sel` set to keyboard (code 2). Opcode 1010 raises `tty_wr` and leaves `wr_en` at 0.
- R8: `pc_kind` is 1, 2, 3, 4 and 5 for opcodes 1011, 1100, 1101, 1110 and 1111 respectively. Opcode 1110 requests a write of `wr_idx` = 7 with `wb_sel` set to link (code 3). The other four opcodes leave `wr_en` at 0.
- R9: `wr_en` is 0 whenever the destination index is 0, even if the instruction requests a register write.
- R10: Opcodes 0101 and 0110 are no-ops:
  - `wr_en`, `mem_rd`, `mem_wr` and `tty_wr` are all 0.
  - `pc_kind` is sequential (code 0).
- R11: `mem_rd` and `mem_wr` are never both 1. `pc_kind` is 0 for every opcode below 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word to decode |
| src_a_idx | output | 3 | First register read index |
| src_b_idx | output | 3 | Second register read index (rt, store data, branch compare) |
| wr_en | output | 1 | Register-file write enable, never set for r0 |
| wr_idx | output | 3 | Register-file write index |
| imm_val | output | DATA_W (16) | Extended immediate |
| jaddr | output | 12 | Jump target field |
| alu_op | output | 3 | ALU operation code |
| alu_src_imm | output | 1 | ALU second operand is the immediate when 1 |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 keyboard, 3 link |
| tty_wr | output | 1 | Terminal output strobe |
| pc_kind | output | 3 | PC update: 0 next, 1 equal branch, 2 zero branch, 3 register jump, 4 jump and link, 5 jump |

## Verification
The bench targets the corner cases where the destination index falls on r0:
- a load or keyboard read aimed at r0,
- an R-type write to r0.

A decoder that fails to suppress these writes would corrupt the hardwired zero register.

The bench also checks immediates with bit 5 set under both extension modes, since a single shared extender would give AND/OR a negative mask or turn negative offsets positive. The reserved opcodes are driven with every other bit set, so that a stray enable would show up as a write or memory access on a no-op. The bench also checks that jump-and-link goes to r7 rather than the encoded field.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int INSTR_W  = 16;
  localparam int OPC_W    = 4;
  localparam int RIDX_W   = 3;
  localparam int FUNC_W   = 3;
  localparam int IMM_W    = 6;
  localparam int JADDR_W  = 12;
  localparam logic [RIDX_W-1:0] LINK_REG = 3'd7;

  typedef enum logic [OPC_W-1:0] {
    OPC_RTYPE = 4'h0, OPC_ADDI = 4'h1, OPC_SUBI = 4'h2, OPC_ANDI = 4'h3,
    OPC_ORI   = 4'h4, OPC_RSV5 = 4'h5, OPC_RSV6 = 4'h6, OPC_LOAD = 4'h7,
    OPC_STORE = 4'h8, OPC_KBD  = 4'h9, OPC_TTY  = 4'hA, OPC_BEQ  = 4'hB,
    OPC_BEQZ  = 4'hC, OPC_JR   = 4'hD, OPC_JAL  = 4'hE, OPC_JMP  = 4'hF
  } opc_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_SLT = 3'd2, ALU_SRA = 3'd3,
    ALU_MUL = 3'd4, ALU_AND = 3'd5, ALU_OR  = 3'd6, ALU_NOT = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0, WB_MEM = 2'd1, WB_KBD = 2'd2, WB_LINK = 2'd3
  } wb_sel_e;

  typedef enum logic [2:0] {
    PC_SEQ = 3'd0, PC_BEQ = 3'd1, PC_BEQZ = 3'd2, PC_JR = 3'd3,
    PC_JAL = 3'd4, PC_JMP = 3'd5
  } pc_kind_e;

  typedef struct packed {
    logic     wr_req;
    logic     dst_from_c;
    logic     dst_link;
    alu_op_e  alu_op;
    logic     alu_src_imm;
    logic     imm_signed;
    logic     mem_rd;
    logic     mem_wr;
    wb_sel_e  wb_sel;
    logic     tty_wr;
    pc_kind_e pc_kind;
  } ctrl_t;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic [OPC_W-1:0]   opcode,
  output logic [FUNC_W-1:0]  func,
  output logic [RIDX_W-1:0]  fld_a,
  output logic [RIDX_W-1:0]  fld_b,
  output logic [RIDX_W-1:0]  fld_c,
  output logic [IMM_W-1:0]   imm_raw,
  output logic [JADDR_W-1:0] jaddr
);
  localparam int A_LSB = INSTR_W - OPC_W - RIDX_W;
  localparam int B_LSB = A_LSB - RIDX_W;
  localparam int C_LSB = B_LSB - RIDX_W;

  assign opcode  = instr[INSTR_W-1 -: OPC_W];
  assign fld_a   = instr[A_LSB +: RIDX_W];
  assign fld_b   = instr[B_LSB +: RIDX_W];
  assign fld_c   = instr[C_LSB +: RIDX_W];
  assign func    = instr[FUNC_W-1:0];
  assign imm_raw = instr[IMM_W-1:0];
  assign jaddr   = instr[JADDR_W-1:0];
endmodule

// File: rtl/idec_immext.sv
module idec_immext #(
  parameter int IMM_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic [IMM_W-1:0]  imm_raw,
  input  logic              signed_mode,
  output logic [DATA_W-1:0] imm_out
);
  localparam int PAD_W = DATA_W - IMM_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic fill;
      assign fill    = signed_mode & imm_raw[IMM_W-1];
      assign imm_out = {{PAD_W{fill}}, imm_raw};
    end else begin : g_trunc
      logic unused_mode;
      assign unused_mode = signed_mode;
      assign imm_out     = imm_raw[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FUNC_W-1:0] func,
  output ctrl_t             ctrl
);
  ctrl_t c;

  always_comb begin
    c             = '0;
    c.alu_op      = ALU_ADD;
    c.wb_sel      = WB_ALU;
    c.pc_kind     = PC_SEQ;
    c.imm_signed  = 1'b1;
    case (opc_e'(opcode))
      OPC_RTYPE: begin
        c.wr_req     = 1'b1;
        c.dst_from_c = 1'b1;
        c.alu_op     = alu_op_e'(func);
      end
      OPC_ADDI: begin
        c.wr_req = 1'b1; c.alu_src_imm = 1'b1;
      end
      OPC_SUBI: begin
        c.wr_req = 1'b1; c.alu_src_imm = 1'b1; c.alu_op = ALU_SUB;
      end
      OPC_ANDI: begin
        c.wr_req = 1'b1; c.alu_src_imm = 1'b1; c.alu_op = ALU_AND;
        c.imm_signed = 1'b0;
      end
      OPC_ORI: begin
        c.wr_req = 1'b1; c.alu_src_imm = 1'b1; c.alu_op = ALU_OR;
        c.imm_signed = 1'b0;
      end
      OPC_LOAD: begin
        c.wr_req = 1'b1; c.alu_src_imm = 1'b1; c.mem_rd = 1'b1;
        c.wb_sel = WB_MEM;
      end
      OPC_STORE: begin
        c.alu_src_imm = 1'b1; c.mem_wr = 1'b1;
      end
      OPC_KBD: begin
        c.wr_req = 1'b1; c.wb_sel = WB_KBD;
      end
      OPC_TTY:  c.tty_wr = 1'b1;
      OPC_BEQ: begin
        c.pc_kind = PC_BEQ; c.alu_op = ALU_SUB;
      end
      OPC_BEQZ: c.pc_kind = PC_BEQZ;
      OPC_JR:   c.pc_kind = PC_JR;
      OPC_JAL: begin
        c.pc_kind = PC_JAL; c.wr_req = 1'b1; c.dst_link = 1'b1;
        c.wb_sel  = WB_LINK;
      end
      OPC_JMP:  c.pc_kind = PC_JMP;
      default: ;
    endcase

    // R11: one memory direction per instruction
    a_r11_mem_exclusive: assert (!(c.mem_rd && c.mem_wr));
    // R10: reserved opcodes stay silent
    a_r10_nop_quiet: assert (!((opcode == 4'h5 || opcode == 4'h6) &&
                               (c.wr_req || c.mem_rd || c.mem_wr || c.tty_wr ||
                                c.pc_kind != PC_SEQ)));
    // R6: stores never write a register
    a_r6_store_no_wr: assert (!(c.mem_wr && c.wr_req));
    // R8: link write-back only on jump-and-link
    a_r8_link_on_jal: assert (!((c.wb_sel == WB_LINK) && (c.pc_kind != PC_JAL)));
  end

  assign ctrl = c;
endmodule

// File: rtl/idec_dest.sv
module idec_dest
  import idec_pkg::*;
(
  input  ctrl_t             ctrl,
  input  logic [RIDX_W-1:0] fld_b,
  input  logic [RIDX_W-1:0] fld_c,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx
);
  logic [RIDX_W-1:0] idx;
  logic              en;

  always_comb begin
    if (ctrl.dst_link)        idx = LINK_REG;
    else if (ctrl.dst_from_c) idx = fld_c;
    else                      idx = fld_b;
    en = ctrl.wr_req && (idx != '0);

    // R9: nothing reaches r0
    a_r9_no_r0_write: assert (!(en && idx == '0));
    // R8: link writes land in the return-address register
    a_r8_link_dest: assert (!(ctrl.dst_link && en && idx != LINK_REG));
  end

  assign wr_en  = en;
  assign wr_idx = idx;
endmodule

// File: rtl/instr_decode.sv
module instr_decode
  import idec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [15:0]       instr,
  output logic [2:0]        src_a_idx,
  output logic [2:0]        src_b_idx,
  output logic              wr_en,
  output logic [2:0]        wr_idx,
  output logic [DATA_W-1:0] imm_val,
  output logic [11:0]       jaddr,
  output logic [2:0]        alu_op,
  output logic              alu_src_imm,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [1:0]        wb_sel,
  output logic              tty_wr,
  output logic [2:0]        pc_kind
);
  logic [OPC_W-1:0]  opcode;
  logic [FUNC_W-1:0] func;
  logic [RIDX_W-1:0] fld_c;
  logic [IMM_W-1:0]  imm_raw;
  ctrl_t             ctrl;

  idec_fields u_fields (
    .instr(instr), .opcode(opcode), .func(func), .fld_a(src_a_idx),
    .fld_b(src_b_idx), .fld_c(fld_c), .imm_raw(imm_raw), .jaddr(jaddr)
  );

  idec_ctrl u_ctrl (.opcode(opcode), .func(func), .ctrl(ctrl));

  idec_immext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_imm (
    .imm_raw(imm_raw), .signed_mode(ctrl.imm_signed), .imm_out(imm_val)
  );

  idec_dest u_dest (
    .ctrl(ctrl), .fld_b(src_b_idx), .fld_c(fld_c),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  assign alu_op      = ctrl.alu_op;
  assign alu_src_imm = ctrl.alu_src_imm;
  assign mem_rd      = ctrl.mem_rd;
  assign mem_wr      = ctrl.mem_wr;
  assign wb_sel      = ctrl.wb_sel;
  assign tty_wr      = ctrl.tty_wr;
  assign pc_kind     = ctrl.pc_kind;
endmodule

// File: tb/tb_instr_decode.sv
module tb_instr_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] instr;
  logic [2:0]  src_a_idx, src_b_idx, wr_idx, alu_op, pc_kind;
  logic        wr_en, alu_src_imm, mem_rd, mem_wr, tty_wr;
  logic [15:0] imm_val;
  logic [11:0] jaddr;
  logic [1:0]  wb_sel;

  int n_chk = 0;
  int n_bad = 0;

  instr_decode dut (
    .instr(instr), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .imm_val(imm_val), .jaddr(jaddr),
    .alu_op(alu_op), .alu_src_imm(alu_src_imm), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .wb_sel(wb_sel), .tty_wr(tty_wr), .pc_kind(pc_kind)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_r(int rs, int rt, int rd, int fn);
    return {4'h0, 3'(rs), 3'(rt), 3'(rd), 3'(fn)};
  endfunction
  function automatic logic [15:0] mk_i(int op, int rs, int rd, int imm);
    return {4'(op), 3'(rs), 3'(rd), 6'(imm)};
  endfunction

  task automatic apply(logic [15:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  task automatic t_reset;
    apply(16'h0000);
    chk("R9", "wr_en on r0 add", int'(wr_en), 0);
    chk("R11", "pc_kind idle", int'(pc_kind), 0);
    chk("R11", "mem strobes idle", int'({mem_rd, mem_wr}), 0);
  endtask

  task automatic t_rtype;
    for (int f = 0; f < 8; f++) begin
      apply(mk_r(3, 5, 6, f));
      chk("R2", "alu_op", int'(alu_op), f);
      chk("R2", "alu_src_imm", int'(alu_src_imm), 0);
      chk("R2", "wr_idx", int'(wr_idx), 6);
      chk("R2", "wr_en", int'(wr_en), 1);
      chk("R2", "wb_sel", int'(wb_sel), 0);
      chk("R1", "src_a", int'(src_a_idx), 3);
      chk("R1", "src_b", int'(src_b_idx), 5);
    end
  endtask

  task automatic t_iarith;
    apply(mk_i(1, 2, 4, 6'h3F));
    chk("R3", "addi alu", int'(alu_op), 0);
    chk("R3", "addi src", int'(alu_src_imm), 1);
    chk("R3", "addi wr_idx", int'(wr_idx), 4);
    chk("R3", "addi wr_en", int'(wr_en), 1);
    chk("R4", "addi imm neg", int'(imm_val), 16'hFFFF);
    apply(mk_i(1, 2, 4, 6'h1F));
    chk("R4", "addi imm pos", int'(imm_val), 16'h001F);
    apply(mk_i(2, 1, 3, 6'h20));
    chk("R3", "subi alu", int'(alu_op), 1);
    chk("R4", "subi imm", int'(imm_val), 16'hFFE0);
    apply(mk_i(3, 1, 3, 6'h3F));
    chk("R3", "andi alu", int'(alu_op), 5);
    chk("R4", "andi imm zero-ext", int'(imm_val), 16'h003F);
    apply(mk_i(4, 7, 5, 6'h20));
    chk("R3", "ori alu", int'(alu_op), 6);
    chk("R3", "ori wr_idx", int'(wr_idx), 5);
    chk("R4", "ori imm zero-ext", int'(imm_val), 16'h0020);
  endtask

  task automatic t_load;
    apply(mk_i(7, 1, 2, 6'h30));
    chk("R5", "mem_rd", int'(mem_rd), 1);
    chk("R5", "mem_wr", int'(mem_wr), 0);
    chk("R5", "wb_sel", int'(wb_sel), 1);
    chk("R5", "wr_idx", int'(wr_idx), 2);
    chk("R5", "wr_en", int'(wr_en), 1);
    chk("R5", "alu", int'(alu_op), 0);
    chk("R5", "src_imm", int'(alu_src_imm), 1);
    chk("R4", "load imm", int'(imm_val), 16'hFFF0);
  endtask

  task automatic t_store;
    apply(mk_i(8, 1, 5, 6'h25));
    chk("R6", "mem_wr", int'(mem_wr), 1);
    chk("R6", "mem_rd", int'(mem_rd), 0);
    chk("R6", "wr_en", int'(wr_en), 0);
    chk("R6", "alu", int'(alu_op), 0);
    chk("R6", "src_imm", int'(alu_src_imm), 1);
    chk("R1", "store data idx", int'(src_b_idx), 5);
    chk("R4", "store imm", int'(imm_val), 16'hFFE5);
  endtask

  task automatic t_io;
    apply(mk_i(9, 0, 3, 0));
    chk("R7", "kbd wr_en", int'(wr_en), 1);
    chk("R7", "kbd wr_idx", int'(wr_idx), 3);
    chk("R7", "kbd wb_sel", int'(wb_sel), 2);
    chk("R7", "kbd tty", int'(tty_wr), 0);
    apply(mk_i(10, 4, 6, 0));
    chk("R7", "tty strobe", int'(tty_wr), 1);
    chk("R7", "tty wr_en", int'(wr_en), 0);
    chk("R1", "tty src", int'(src_a_idx), 4);
  endtask

  task automatic t_flow;
    apply(mk_i(11, 2, 3, 6'h15));
    chk("R8", "beq kind", int'(pc_kind), 1);
    chk("R8", "beq wr_en", int'(wr_en), 0);
    apply(mk_i(12, 2, 3, 6'h15));
    chk("R8", "beqz kind", int'(pc_kind), 2);
    chk("R8", "beqz wr_en", int'(wr_en), 0);
    apply(mk_i(13, 6, 1, 0));
    chk("R8", "jr kind", int'(pc_kind), 3);
    chk("R8", "jr wr_en", int'(wr_en), 0);
    apply({4'hE, 12'hABC});
    chk("R8", "jal kind", int'(pc_kind), 4);
    chk("R8", "jal wr_en", int'(wr_en), 1);
    chk("R8", "jal wr_idx", int'(wr_idx), 7);
    chk("R8", "jal wb_sel", int'(wb_sel), 3);
    chk("R1", "jal jaddr", int'(jaddr), 12'hABC);
    apply({4'hF, 12'h123});
    chk("R8", "jmp kind", int'(pc_kind), 5);
    chk("R8", "jmp wr_en", int'(wr_en), 0);
    chk("R1", "jmp jaddr", int'(jaddr), 12'h123);
  endtask

  task automatic t_r0;
    apply(mk_r(1, 2, 0, 0));
    chk("R9", "rtype to r0", int'(wr_en), 0);
    apply(mk_i(1, 3, 0, 5));
    chk("R9", "addi to r0", int'(wr_en), 0);
    apply(mk_i(7, 3, 0, 5));
    chk("R9", "load to r0", int'(wr_en), 0);
    chk("R5", "load to r0 still reads", int'(mem_rd), 1);
    apply(mk_i(9, 0, 0, 0));
    chk("R9", "kbd to r0", int'(wr_en), 0);
  endtask

  task automatic t_nop;
    for (int op = 5; op <= 6; op++) begin
      apply({4'(op), 12'hFFF});
      chk("R10", "nop wr_en", int'(wr_en), 0);
      chk("R10", "nop mem_rd", int'(mem_rd), 0);
      chk("R10", "nop mem_wr", int'(mem_wr), 0);
      chk("R10", "nop tty", int'(tty_wr), 0);
      chk("R10", "nop pc", int'(pc_kind), 0);
    end
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 16; op++) begin
      apply({4'(op), 12'h5A7});
      chk("R11", "mem exclusive", int'(mem_rd & mem_wr), 0);
      if (op < 11) chk("R11", "sequential pc", int'(pc_kind), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    instr = 16'h0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset;
    t_rtype;
    t_iarith;
    t_load;
    t_store;
    t_io;
    t_flow;
    t_r0;
    t_nop;
    t_sweep;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule